// File: doc/BRIEF.md
# RNS Base Extension Unit

This block takes an integer held as residues over a source set of pairwise coprime moduli and produces that integer's residues over a second, coprime target set. It uses the Chinese remainder sum. The number of whole multiples of the source product M_a contained in that sum is not derived exactly. A small estimator adds up a few leading bits of every per-channel weighted residue, plus a fixed fractional offset, and the datapath subtracts that many copies of M_a. Because of this estimate, the target residues may describe X + M_a rather than X. Modular multipliers built on this unit are expected to absorb that slack.

Operation is started by a one-cycle start pulse and takes a fixed number of cycles. First, every source channel forms its weighted residue in parallel. These values are then sent one per cycle to all target channels, and each target channel carries out one modular multiply-accumulate per cycle. After the last term, the estimated multiple of M_a is removed and done pulses. All channel constants (inverses, cofactors and the residues of M_a) are derived during elaboration from the two modulus lists, which are given as parameters.

Top module: `rns_base_extend`

## Requirements
- R1: When start is sampled high while busy is low, busy goes high from the next cycle onward. done rises exactly NA+1 rising edges after the sampling edge, is high for one cycle only, and busy is low in that cycle.
- R2: srcRes is captured only at the edge that accepts start. A start pulse during busy, and any change of srcRes after acceptance, leave the run and its result unaffected.
- R3: Each source channel i computes xi_i = (x_i * inv_i) mod m_i, where inv_i is the inverse of (M_a/m_i) mod m_i. The estimate q is floor((SIGMA0 + sum of the upper T bits of each W-bit xi_i) / 2^T).
- R4: Target channel j, at bits [j*W +: W] of dstRes, is (sum_i xi_i*((M_a/m_i) mod d_j) - q*(M_a mod d_j)) mod d_j. It is fully reduced below d_j.
- R5: With SIGMA0 = 0, each output channel equals X mod d_j or (X + M_a) mod d_j for every input X < M_a.
- R6: With SIGMA0 = 2^(T-1), each output channel equals X mod d_j exactly whenever X < M_a/2.
- R7: After reset, busy, done and dstRes are all zero. dstRes holds its value unchanged while no run is in progress.
- R8: An all-zero input gives an all-zero output for any SIGMA0 below 2^T.
- R9: A start presented in the cycle in which done is high is accepted, so runs can follow each other with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a conversion when the unit is idle |
| srcRes | input | NA*W | Source residues, channel i at bits [i*W +: W] |
| busy | output | 1 | High while a conversion is in progress |
| done | output | 1 | One-cycle pulse when dstRes is valid |
| dstRes | output | NB*W | Target residues, channel j at bits [j*W +: W] |

## Verification
The bench uses inputs that expose the quotient estimate. At large X the fractional sum is near an integer, and at small X the truncation loss can push the estimate one below the true count. A wrong truncation width, a wrong offset or a missing subtraction of M_a shows up as residues that are neither X nor X + M_a, or that miss the exact expected pair. Zero input catches an estimator that fails to clear between runs. A second start during busy and a changed srcRes mid-run catch a controller that restarts or a datapath that reads its input late. A start issued in the done cycle catches a controller that needs an extra idle cycle. Running the same inputs on an instance with a half offset catches a design that is exact only for certain X.

// File: rtl/rns_bx_pkg.sv
package rns_bx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACC,
    ST_FIX
  } bx_state_e;

  // strobes from the controller into the datapath and quotient unit
  typedef struct packed {
    logic load;   // capture inputs, clear accumulators
    logic mac;    // one broadcast term into every target channel
    logic fix;    // subtract the estimated multiple of M_a
  } bx_strobe_t;

  // modular inverse by the extended Euclidean algorithm (elaboration use)
  function automatic int modInv(int a, int m);
    int t  = 0;
    int nt = 1;
    int r  = m;
    int nr = a % m;
    int qq;
    int tmp;
    while (nr != 0) begin
      qq  = r / nr;
      tmp = t - qq * nt;
      t   = nt;
      nt  = tmp;
      tmp = r - qq * nr;
      r   = nr;
      nr  = tmp;
    end
    if (t < 0) t += m;
    return t;
  endfunction

endpackage

// File: rtl/rns_bx_ctrl.sv
module rns_bx_ctrl
  import rns_bx_pkg::*;
#(
  parameter int NA = 3,
  localparam int IW = (NA > 1) ? $clog2(NA) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output bx_strobe_t    str,
  output logic [IW-1:0] idx,
  output logic          busy,
  output logic          done
);

  bx_state_e state;
  bx_state_e stateNext;
  logic      lastTerm;

  assign lastTerm = (idx == IW'(NA - 1));

  always_comb begin
    stateNext = state;
    str       = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          str.load  = 1'b1;
          stateNext = ST_ACC;
        end
      end
      ST_ACC: begin
        str.mac = 1'b1;
        if (lastTerm) stateNext = ST_FIX;
      end
      ST_FIX: begin
        str.fix   = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= str.fix;
      if (str.load)     idx <= '0;
      else if (str.mac) idx <= lastTerm ? '0 : idx + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/rns_bx_qest.sv
module rns_bx_qest
  import rns_bx_pkg::*;
#(
  parameter int NA     = 3,
  parameter int T      = 6,
  parameter int SIGMA0 = 0,
  localparam int ACCW  = $clog2(NA + 1) + T,
  localparam int QW    = ACCW - T
) (
  input  logic          clk,
  input  logic          rstN,
  input  bx_strobe_t    str,
  input  logic [T-1:0]  xiTop,
  output logic [QW-1:0] q
);

  logic [ACCW-1:0] qAcc;

  always_ff @(posedge clk) begin
    if (!rstN)         qAcc <= '0;
    else if (str.load) qAcc <= ACCW'(SIGMA0);
    else if (str.mac)  qAcc <= qAcc + ACCW'(xiTop);
  end

  assign q = qAcc[ACCW-1:T];

endmodule

// File: rtl/rns_bx_datapath.sv
module rns_bx_datapath
  import rns_bx_pkg::*;
#(
  parameter int W  = 8,
  parameter int NA = 3,
  parameter int NB = 3,
  parameter int T  = 6,
  parameter int QW = 2,
  parameter logic [NA*W-1:0] SRC_MODS = {8'd239, 8'd241, 8'd251},
  parameter logic [NB*W-1:0] DST_MODS = {8'd227, 8'd229, 8'd233},
  localparam int IW = (NA > 1) ? $clog2(NA) : 1,
  localparam int SW = 2 * W + 1,
  localparam int FW = QW + W + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  bx_strobe_t      str,
  input  logic [IW-1:0]   idx,
  input  logic [NA*W-1:0] srcRes,
  input  logic [QW-1:0]   q,
  output logic [T-1:0]    xiTop,
  output logic [NB*W-1:0] dstRes
);

  // product of source moduli other than 'skip', reduced by md (skip<0: all)
  function automatic int prodExcept(int skip, int md);
    longint p = 1;
    for (int k = 0; k < NA; k++) begin
      if (k != skip) p = (p * longint'(SRC_MODS[k*W +: W])) % longint'(md);
    end
    return int'(p);
  endfunction

  logic [NA*W-1:0] xiNext;
  logic [NA*W-1:0] xiVec;
  logic [W-1:0]    xiSel;
  logic [NB*W-1:0] accNext;

  // weighted residue per source channel, all in parallel at load
  for (genvar gi = 0; gi < NA; gi++) begin : g_src
    localparam int MI  = int'(SRC_MODS[gi*W +: W]);
    localparam int INV = modInv(prodExcept(gi, MI), MI);
    localparam logic [2*W-1:0] MODW = (2*W)'(MI);
    logic [2*W-1:0] prod;
    logic [2*W-1:0] red;
    assign prod = (2*W)'(srcRes[gi*W +: W]) * (2*W)'(INV);
    assign red  = prod % MODW;
    assign xiNext[gi*W +: W] = red[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)         xiVec <= '0;
    else if (str.load) xiVec <= xiNext;
  end

  assign xiSel = xiVec[idx*W +: W];
  assign xiTop = xiSel[W-1 -: T];

  // one modular multiply-accumulate per cycle in every target channel
  for (genvar gj = 0; gj < NB; gj++) begin : g_dst
    localparam int MJ    = int'(DST_MODS[gj*W +: W]);
    localparam int NEGMA = (MJ - prodExcept(-1, MJ)) % MJ;
    localparam logic [SW-1:0] MODS = SW'(MJ);
    localparam logic [FW-1:0] MODF = FW'(MJ);
    logic [W-1:0]  cTab [NA];
    logic [W-1:0]  cSel;
    logic [W-1:0]  accCur;
    logic [SW-1:0] macSum;
    logic [SW-1:0] macRed;
    logic [FW-1:0] fixSum;
    logic [FW-1:0] fixRed;

    for (genvar gi = 0; gi < NA; gi++) begin : g_cof
      localparam int COF = prodExcept(gi, MJ);
      assign cTab[gi] = W'(COF);
    end

    assign cSel   = cTab[idx];
    assign accCur = dstRes[gj*W +: W];
    assign macSum = SW'(accCur) + SW'(xiSel) * SW'(cSel);
    assign macRed = macSum % MODS;
    assign fixSum = FW'(accCur) + FW'(q) * FW'(NEGMA);
    assign fixRed = fixSum % MODF;
    assign accNext[gj*W +: W] = str.fix ? fixRed[W-1:0] : macRed[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  dstRes <= '0;
    else if (str.load)          dstRes <= '0;
    else if (str.mac | str.fix) dstRes <= accNext;
  end

endmodule

// File: rtl/rns_base_extend.sv
module rns_base_extend
  import rns_bx_pkg::*;
#(
  parameter int W      = 8,
  parameter int NA     = 3,
  parameter int NB     = 3,
  parameter int T      = 6,
  parameter int SIGMA0 = 0,
  parameter logic [NA*W-1:0] SRC_MODS = {8'd239, 8'd241, 8'd251},
  parameter logic [NB*W-1:0] DST_MODS = {8'd227, 8'd229, 8'd233}
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [NA*W-1:0] srcRes,
  output logic            busy,
  output logic            done,
  output logic [NB*W-1:0] dstRes
);

  localparam int IW = (NA > 1) ? $clog2(NA) : 1;
  localparam int QW = $clog2(NA + 1);

  bx_strobe_t    str;
  logic [IW-1:0] idx;
  logic [QW-1:0] q;
  logic [T-1:0]  xiTop;

  rns_bx_ctrl #(.NA(NA)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .str(str), .idx(idx), .busy(busy), .done(done)
  );

  rns_bx_qest #(.NA(NA), .T(T), .SIGMA0(SIGMA0)) uQest (
    .clk(clk), .rstN(rstN), .str(str), .xiTop(xiTop), .q(q)
  );

  rns_bx_datapath #(
    .W(W), .NA(NA), .NB(NB), .T(T), .QW(QW),
    .SRC_MODS(SRC_MODS), .DST_MODS(DST_MODS)
  ) uDp (
    .clk(clk), .rstN(rstN), .str(str), .idx(idx), .srcRes(srcRes),
    .q(q), .xiTop(xiTop), .dstRes(dstRes)
  );

endmodule

// File: rtl/rns_bx_check.sv
module rns_bx_check #(
  parameter int W  = 8,
  parameter int NA = 3,
  parameter int NB = 3,
  parameter logic [NB*W-1:0] DST_MODS = {8'd227, 8'd229, 8'd233}
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [NB*W-1:0] dstRes
);

  int cnt;

  always_ff @(posedge clk) begin
    if (!rstN)                cnt <= 0;
    else if (start && !busy)  cnt <= 1;
    else if (done)            cnt <= 0;
    else if (cnt != 0)        cnt <= cnt + 1;
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cnt == NA + 2));

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(dstRes));

  for (genvar gj = 0; gj < NB; gj++) begin : g_rng
    p_reduced_r4: assert property (@(posedge clk) disable iff (!rstN)
      done |-> (dstRes[gj*W +: W] < DST_MODS[gj*W +: W]));
  end

endmodule

bind rns_base_extend rns_bx_check #(
  .W(W), .NA(NA), .NB(NB), .DST_MODS(DST_MODS)
) uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy),
  .done(done), .dstRes(dstRes)
);

// File: tb/tb_rns_base_extend.sv
module tb_rns_base_extend;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int NA = 3;
  localparam int NB = 3;
  localparam int T  = 6;
  localparam int SM [NA] = '{251, 241, 239};
  localparam int DM [NB] = '{233, 229, 227};
  localparam int HALF = 1 << (T - 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [NA*W-1:0] srcRes = '0;
  logic busy, done, busyO, doneO;
  logic [NB*W-1:0] dOut, dOfs;

  int checks = 0;
  int errors = 0;
  longint ma = 1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rns_base_extend #(.W(W), .NA(NA), .NB(NB), .T(T), .SIGMA0(0),
    .SRC_MODS({8'd239, 8'd241, 8'd251}), .DST_MODS({8'd227, 8'd229, 8'd233})
  ) dut (.clk(clk), .rstN(rstN), .start(start), .srcRes(srcRes),
         .busy(busy), .done(done), .dstRes(dOut));

  rns_base_extend #(.W(W), .NA(NA), .NB(NB), .T(T), .SIGMA0(HALF),
    .SRC_MODS({8'd239, 8'd241, 8'd251}), .DST_MODS({8'd227, 8'd229, 8'd233})
  ) dutOfs (.clk(clk), .rstN(rstN), .start(start), .srcRes(srcRes),
            .busy(busyO), .done(doneO), .dstRes(dOfs));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int bInv(int a, int m);
    for (int k = 1; k < m; k++) if ((longint'(a) * k) % m == 1) return k;
    return 0;
  endfunction

  function automatic logic [NA*W-1:0] toRes(longint x);
    logic [NA*W-1:0] r;
    for (int i = 0; i < NA; i++) r[i*W +: W] = W'(x % SM[i]);
    return r;
  endfunction

  // expected channel value from the requirement formulas (R3, R4)
  function automatic longint expRes(longint x, int sig, int j);
    longint s = 0;
    longint y;
    int acc = sig;
    for (int i = 0; i < NA; i++) begin
      longint mi = ma / SM[i];
      longint xr = x % SM[i];
      longint e  = (xr * bInv(int'(mi % SM[i]), SM[i])) % SM[i];
      s   += e * mi;
      acc += int'(e) >> (W - T);
    end
    y = s - longint'(acc >> T) * ma;
    y = y % DM[j];
    if (y < 0) y += DM[j];
    return y;
  endfunction

  function automatic longint chan(logic [NB*W-1:0] v, int j);
    return longint'(v[j*W +: W]);
  endfunction

  // waits from the negedge after acceptance; returns negedges counted
  task automatic waitDone(output int lat);
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic checkOut(input longint x, input string tag);
    for (int j = 0; j < NB; j++) begin
      longint a  = chan(dOut, j);
      longint ao = chan(dOfs, j);
      longint xm = x % DM[j];
      longint xp = (x + ma) % DM[j];
      chk(a == expRes(x, 0, j), {"R4 ", tag}, a, expRes(x, 0, j));
      chk(a == xm || a == xp, {"R5 ", tag}, a, xm);
      chk(ao == expRes(x, HALF, j), {"R3 ", tag}, ao, expRes(x, HALF, j));
      if (x < ma / 2) chk(ao == xm, {"R6 ", tag}, ao, xm);
    end
  endtask

  task automatic runOne(input longint x, input string tag);
    int lat;
    @(negedge clk);
    srcRes = toRes(x);
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(lat);
    chk(lat == NA + 2, {"R1 latency ", tag}, lat, NA + 2);
    checkOut(x, tag);
    @(negedge clk);
    chk(done == 1'b0, {"R1 pulse ", tag}, done, 0);
  endtask

  task automatic testReset();
    chk(busy == 1'b0, "R7 reset busy", busy, 0);
    chk(done == 1'b0, "R7 reset done", done, 0);
    chk(dOut == '0, "R7 reset dstRes", dOut, 0);
  endtask

  task automatic testZero();
    runOne(0, "zero");
    for (int j = 0; j < NB; j++) begin
      chk(chan(dOut, j) == 0, "R8 zero", chan(dOut, j), 0);
      chk(chan(dOfs, j) == 0, "R8 zero ofs", chan(dOfs, j), 0);
    end
  endtask

  task automatic testEdges();
    runOne(1, "one");
    runOne(ma / 3, "third");
    runOne(ma / 2 - 1, "half-1");
    runOne(ma - 1, "max");
    runOne(ma - 2, "max-1");
    runOne(longint'(SM[0]) * SM[1], "m0m1");
  endtask

  task automatic testPatterns();
    longint s = 12345;
    for (int n = 0; n < 12; n++) begin
      s = (s * 1103515245 + 12345) & 64'h7fffffff;
      runOne(s % ma, "pattern");
    end
  endtask

  task automatic testIgnore();
    int lat;
    longint x = ma - 777;
    @(negedge clk);
    srcRes = toRes(x);
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    srcRes = toRes(55);
    @(negedge clk);
    start = 1'b1;           // start while busy, R2
    @(negedge clk);
    start = 1'b0;
    lat = 3;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == NA + 2, "R2 latency with busy start", lat, NA + 2);
    checkOut(x, "ignore");
    @(negedge clk);
    chk(busy == 1'b0, "R2 no restart", busy, 0);
  endtask

  task automatic testHold();
    logic [NB*W-1:0] held;
    runOne(424242, "hold");
    held = dOut;
    srcRes = toRes(99);
    repeat (5) @(negedge clk);
    chk(dOut == held, "R7 hold", dOut, held);
  endtask

  task automatic testBackToBack();
    int lat;
    longint x1 = 3141592;
    longint x2 = ma - 31337;
    @(negedge clk);
    srcRes = toRes(x1);
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(lat);
    checkOut(x1, "b2b first");
    srcRes = toRes(x2);    // presented in the done cycle, R9
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(lat);
    chk(lat == NA + 2, "R9 back-to-back latency", lat, NA + 2);
    checkOut(x2, "b2b second");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NA; i++) ma *= SM[i];
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testZero();
    testEdges();
    testPatterns();
    testIgnore();
    testHold();
    testBackToBack();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule